// File: doc/BRIEF.md
# Processor Control Register File

This block keeps the machine-wide control state of a 32-bit processor core. It holds three registers: a machine control word, a fault-address register and a page-table root register. The core's execute stage writes them with full 32-bit moves. It can also load or store only the low 16 bits of the control word, which form the status word. The block reacts to three events from the rest of the core. On a task switch it sets the task-switched flag. On a page fault it records the faulting linear address. When the core issues a coprocessor escape opcode or a WAIT opcode, it decides whether that opcode must trap.

A trap is reported one cycle after the opcode as a valid flag with vector number 7. A single-cycle flush pulse tells the translation cache to drop its entries after a task switch or after a new page-table root is written. The decoded paging-enable and protection-enable bits are driven out directly for the rest of the core.

Top module: `cr_file_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all three registers to zero and drops `exc_valid` and `tlb_flush`. After reset `paging_en` and `prot_en` are 0.
- R2: A full write (`wr_en`=1, `wr_sel`=0) loads the control word. Bit 31 (paging), bit 3 (task switched), bit 2 (emulate), bit 1 (monitor) and bit 0 (protection) take the written data. Every other bit, including reserved bit 4, reads 0. `paging_en` follows bit 31 and `prot_en` follows bit 0.
- R3: A status-word load (`msw_ld`=1) changes only bits 3..1 of the control word, which take `msw_data[3:1]`. Bit 0 becomes the old bit 0 OR `msw_data[0]`, so this load can set bit 0 but never clear it. Bit 31 is unchanged. `msw_out` always shows bits 15..0 of the control word.
- R4: `task_switch` sets bit 3 of the control word at the next edge. This holds even when a same-cycle write would clear that bit.
- R5: An escape opcode (`esc_op`) raises `exc_valid` one cycle later, with `exc_vector`=7, when the emulate bit or the task-switched bit is set.
- R6: A WAIT opcode (`wait_op`) raises `exc_valid` one cycle later, with `exc_vector`=7, only when both the monitor bit and the task-switched bit are set.
- R7: `pf_valid` loads `pf_addr` into the fault-address register (`wr_sel`=2) and has priority over a same-cycle full write to it. A full write to `wr_sel`=2 loads it otherwise.
- R8: A full write to `wr_sel`=3 stores bits 31..12 of the page-table root. Bits 11..0 read back as 0.
- R9: `tlb_flush` is high for exactly the one cycle after a task switch or after a write to `wr_sel`=3, and low otherwise.
- R10: `wr_sel`=1 is reserved. A write there changes no register, and reading it returns 0.
- R11: When a full control-word write and a status-word load arrive in the same cycle, the full write wins and the status-word load is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Full 32-bit register write strobe |
| wr_sel | input | 2 | Write target: 0 control word, 1 reserved, 2 fault address, 3 page-table root |
| wr_data | input | 32 | Full write data |
| msw_ld | input | 1 | Status-word load strobe |
| msw_data | input | 16 | Status-word load data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 32 | Combinational read of the selected register |
| msw_out | output | 16 | Current status word (control word bits 15..0) |
| task_switch | input | 1 | Task switch event |
| pf_valid | input | 1 | Page fault detected |
| pf_addr | input | 32 | Faulting linear address |
| esc_op | input | 1 | Coprocessor escape opcode issued |
| wait_op | input | 1 | WAIT opcode issued |
| exc_valid | output | 1 | Coprocessor-unavailable trap, one cycle after the opcode |
| exc_vector | output | 8 | Trap vector, 7 while `exc_valid` is high, else 0 |
| tlb_flush | output | 1 | One-cycle translation-cache flush |
| paging_en | output | 1 | Control word bit 31 |
| prot_en | output | 1 | Control word bit 0 |

## Verification
The hardest cases to reach are the trap decisions that depend on the task-switched flag. That flag can only be combined with a cleared emulate bit through a particular sequence. First a status-word load sets protection and monitor. Then a zero load shows that protection stays set while monitor clears. Next a task switch sets the flag, and a WAIT and an escape opcode are issued to show the two different trap rules. Finally a status-word load that sets monitor and task-switched together enables the WAIT trap. The stimulus table walks through this sequence in order. Same-cycle collisions are driven as single vectors: full write against status-word load, task switch against a clearing write, and fault against a write to the fault-address register.

// File: rtl/cr_pkg.sv
package cr_pkg;

    localparam int XLEN       = 32;
    localparam int MSW_W      = 16;
    localparam int PAGE_SHIFT = 12;
    localparam int VEC_W      = 8;
    localparam int COP_VECTOR = 7;

    localparam int PG_BIT = 31;
    localparam int TS_BIT = 3;
    localparam int EM_BIT = 2;
    localparam int MP_BIT = 1;
    localparam int PE_BIT = 0;

    typedef enum logic [1:0] {
        SEL_MCW = 2'd0,
        SEL_RSV = 2'd1,
        SEL_PFA = 2'd2,
        SEL_PDB = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pg;
        logic ts;
        logic em;
        logic mp;
        logic pe;
    } mcw_t;

    function automatic logic [XLEN-1:0] mcw_word(mcw_t m);
        logic [XLEN-1:0] w;
        w         = '0;
        w[PG_BIT] = m.pg;
        w[TS_BIT] = m.ts;
        w[EM_BIT] = m.em;
        w[MP_BIT] = m.mp;
        w[PE_BIT] = m.pe;
        return w;
    endfunction

    function automatic mcw_t mcw_from_word(logic [XLEN-1:0] w);
        mcw_t m;
        m.pg = w[PG_BIT];
        m.ts = w[TS_BIT];
        m.em = w[EM_BIT];
        m.mp = w[MP_BIT];
        m.pe = w[PE_BIT];
        return m;
    endfunction

    function automatic mcw_t msw_merge(mcw_t cur, logic [MSW_W-1:0] d);
        mcw_t m;
        m    = cur;
        m.ts = d[TS_BIT];
        m.em = d[EM_BIT];
        m.mp = d[MP_BIT];
        m.pe = cur.pe | d[PE_BIT];
        return m;
    endfunction

endpackage

// File: rtl/cr_mcw.sv
module cr_mcw
    import cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             full_we,
    input  logic [XLEN-1:0]  full_data,
    input  logic             msw_we,
    input  logic [MSW_W-1:0] msw_data,
    input  logic             task_switch,
    output mcw_t             q
);

    mcw_t nxt;

    always_comb begin
        nxt = q;
        if (full_we) begin
            nxt = mcw_from_word(full_data);
        end else if (msw_we) begin
            nxt = msw_merge(q, msw_data);
        end
        if (task_switch) begin
            nxt.ts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q == '0));

    assert_pe_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (q.pe && msw_we && !full_we) |=> q.pe);

    assert_pg_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (msw_we && !full_we) |=> (q.pg == $past(q.pg)));

    assert_ts_set_R4: assert property (@(posedge clk) disable iff (rst)
        task_switch |=> q.ts);

    assert_full_wins_R11: assert property (@(posedge clk) disable iff (rst)
        (full_we && msw_we && !task_switch) |=> (q.pe == $past(full_data[PE_BIT])));

endmodule

// File: rtl/cr_addr_regs.sv
module cr_addr_regs
    import cr_pkg::*;
#(
    parameter int SHIFT = PAGE_SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pfa_we,
    input  logic            pdb_we,
    input  logic [XLEN-1:0] wdata,
    input  logic            pf_valid,
    input  logic [XLEN-1:0] pf_addr,
    input  logic            task_switch,
    output logic [XLEN-1:0] pfa_q,
    output logic [XLEN-1:0] pdb_q,
    output logic            flush
);

    localparam int BASE_W = XLEN - SHIFT;

    logic [BASE_W-1:0] pdb_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            pfa_q    <= '0;
            pdb_base <= '0;
            flush    <= 1'b0;
        end else begin
            if (pf_valid) begin
                pfa_q <= pf_addr;
            end else if (pfa_we) begin
                pfa_q <= wdata;
            end
            if (pdb_we) begin
                pdb_base <= wdata[XLEN-1:SHIFT];
            end
            flush <= task_switch | pdb_we;
        end
    end

    assign pdb_q = {pdb_base, {SHIFT{1'b0}}};

    logic unused_low_bits;
    assign unused_low_bits = ^wdata[SHIFT-1:0];

    assert_pf_capture_R7: assert property (@(posedge clk) disable iff (rst)
        pf_valid |=> (pfa_q == $past(pf_addr)));

    assert_pdb_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
        pdb_we |=> (pdb_q[SHIFT-1:0] == '0));

    assert_flush_on_switch_R9: assert property (@(posedge clk) disable iff (rst)
        (task_switch || pdb_we) |=> flush);

    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!task_switch && !pdb_we) |=> !flush);

endmodule

// File: rtl/cr_cop_trap.sv
module cr_cop_trap
    import cr_pkg::*;
#(
    parameter int VECTOR = COP_VECTOR
) (
    input  logic             clk,
    input  logic             rst,
    input  mcw_t             mcw,
    input  logic             esc_op,
    input  logic             wait_op,
    output logic             exc_valid,
    output logic [VEC_W-1:0] exc_vector
);

    logic esc_trap;
    logic wait_trap;

    assign esc_trap  = esc_op  & (mcw.em | mcw.ts);
    assign wait_trap = wait_op & mcw.mp & mcw.ts;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_valid  <= 1'b0;
            exc_vector <= '0;
        end else begin
            exc_valid  <= esc_trap | wait_trap;
            exc_vector <= (esc_trap | wait_trap) ? VEC_W'(VECTOR) : '0;
        end
    end

    assert_esc_em_R5: assert property (@(posedge clk) disable iff (rst)
        (esc_op && mcw.em) |=> exc_valid);

    assert_vector_R5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_vector == VEC_W'(VECTOR)));

    assert_wait_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (wait_op && mcw.mp && mcw.ts) |=> exc_valid);

    assert_wait_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (wait_op && !esc_op && !(mcw.mp && mcw.ts)) |=> !exc_valid);

endmodule

// File: rtl/cr_file_top.sv
module cr_file_top
    import cr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic        msw_ld,
    input  logic [15:0] msw_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data,
    output logic [15:0] msw_out,
    input  logic        task_switch,
    input  logic        pf_valid,
    input  logic [31:0] pf_addr,
    input  logic        esc_op,
    input  logic        wait_op,
    output logic        exc_valid,
    output logic [7:0]  exc_vector,
    output logic        tlb_flush,
    output logic        paging_en,
    output logic        prot_en
);

    reg_sel_e        wsel;
    reg_sel_e        rsel;
    mcw_t            mcw;
    logic [XLEN-1:0] mcw_w;
    logic [XLEN-1:0] pfa_q;
    logic [XLEN-1:0] pdb_q;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    cr_mcw u_mcw (
        .clk         (clk),
        .rst         (rst),
        .full_we     (wr_en && (wsel == SEL_MCW)),
        .full_data   (wr_data),
        .msw_we      (msw_ld),
        .msw_data    (msw_data),
        .task_switch (task_switch),
        .q           (mcw)
    );

    cr_addr_regs #(.SHIFT(PAGE_SHIFT)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .pfa_we      (wr_en && (wsel == SEL_PFA)),
        .pdb_we      (wr_en && (wsel == SEL_PDB)),
        .wdata       (wr_data),
        .pf_valid    (pf_valid),
        .pf_addr     (pf_addr),
        .task_switch (task_switch),
        .pfa_q       (pfa_q),
        .pdb_q       (pdb_q),
        .flush       (tlb_flush)
    );

    cr_cop_trap #(.VECTOR(COP_VECTOR)) u_trap (
        .clk        (clk),
        .rst        (rst),
        .mcw        (mcw),
        .esc_op     (esc_op),
        .wait_op    (wait_op),
        .exc_valid  (exc_valid),
        .exc_vector (exc_vector)
    );

    assign mcw_w     = mcw_word(mcw);
    assign msw_out   = mcw_w[MSW_W-1:0];
    assign paging_en = mcw.pg;
    assign prot_en   = mcw.pe;

    always_comb begin
        case (rsel)
            SEL_MCW: rd_data = mcw_w;
            SEL_PFA: rd_data = pfa_q;
            SEL_PDB: rd_data = pdb_q;
            default: rd_data = '0;
        endcase
    end

    assert_rsv_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wsel == SEL_RSV && !msw_ld && !task_switch && !pf_valid)
            |=> ($stable(mcw) && $stable(pfa_q) && $stable(pdb_q)));

    assert_rsv_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rsel == SEL_RSV) |-> (rd_data == '0));

    assert_reserved_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (msw_out[15:4] == '0));

endmodule

// File: tb/test_cr_file_top.sv
`timescale 1ns/1ps
module test_cr_file_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        msw_ld;
    logic [15:0] msw_data;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic [15:0] msw_out;
    logic        task_switch;
    logic        pf_valid;
    logic [31:0] pf_addr;
    logic        esc_op;
    logic        wait_op;
    logic        exc_valid;
    logic [7:0]  exc_vector;
    logic        tlb_flush;
    logic        paging_en;
    logic        prot_en;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cr_file_top i_cr_file_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .msw_ld(msw_ld), .msw_data(msw_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .msw_out(msw_out), .task_switch(task_switch), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .esc_op(esc_op), .wait_op(wait_op),
        .exc_valid(exc_valid), .exc_vector(exc_vector), .tlb_flush(tlb_flush),
        .paging_en(paging_en), .prot_en(prot_en)
    );

    typedef struct packed {
        logic        wen;
        logic [1:0]  sel;
        logic [31:0] wd;
        logic        mld;
        logic [15:0] md;
        logic        tsw;
        logic        esc;
        logic        wt;
        logic        pf;
        logic [31:0] pa;
        logic [1:0]  rsel;
        logic [31:0] exp;
        logic        ex;
        logic        fl;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R2: full write, only defined bits survive
        '{1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h8000_000F, 1'b0, 1'b0},
        // R5: escape with emulate set traps
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 2'd0, 32'h8000_000F, 1'b1, 1'b0},
        // R2: full write clears everything
        '{1'b1, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0, 1'b0, 1'b0},
        // R3: status-word load sets protection and monitor
        '{1'b0, 2'd0, 32'h0, 1'b1, 16'h0003, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0003, 1'b0, 1'b0},
        // R3: zero load keeps protection, clears monitor
        '{1'b0, 2'd0, 32'h0, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0001, 1'b0, 1'b0},
        // R4 R9: task switch sets flag and flushes
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0009, 1'b0, 1'b1},
        // R6: WAIT with monitor clear does not trap
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0, 32'h0000_0009, 1'b0, 1'b0},
        // R5: escape with task-switched set traps
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0009, 1'b1, 1'b0},
        // R3: load monitor and task-switched, protection sticky
        '{1'b0, 2'd0, 32'h0, 1'b1, 16'h000A, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_000B, 1'b0, 1'b0},
        // R6: WAIT with monitor and task-switched traps
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 2'd0, 32'h0000_000B, 1'b1, 1'b0},
        // R11: full write beats status-word load
        '{1'b1, 2'd0, 32'h8000_0000, 1'b1, 16'h000F, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h8000_0000, 1'b0, 1'b0},
        // R7: fault beats write to fault-address register
        '{1'b1, 2'd2, 32'h1234_5678, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF, 2'd2, 32'hDEAD_BEEF, 1'b0, 1'b0},
        // R7: plain write to fault-address register
        '{1'b1, 2'd2, 32'h1234_5678, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd2, 32'h1234_5678, 1'b0, 1'b0},
        // R8 R9: root write drops low 12 bits and flushes
        '{1'b1, 2'd3, 32'hABCD_EFFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd3, 32'hABCD_E000, 1'b0, 1'b1},
        // R10: reserved write, reserved read is zero
        '{1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd1, 32'h0, 1'b0, 1'b0},
        // R4: task switch beats clearing write
        '{1'b1, 2'd0, 32'h0, 1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0008, 1'b0, 1'b1},
        // R9: flush lasts one cycle only
        '{1'b0, 2'd0, 32'h0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 2'd0, 32'h0000_0008, 1'b0, 1'b0}
    };

    task automatic chk32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; msw_ld = 1'b0; msw_data = '0;
        task_switch = 1'b0; pf_valid = 1'b0; pf_addr = '0; esc_op = 1'b0; wait_op = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rd_sel = 2'd0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.1 chk32("R1 reset read", rd_data, 32'h0);
        end
        chk32("R1 exc_valid", {31'd0, exc_valid}, 32'd0);
        chk32("R1 tlb_flush", {31'd0, tlb_flush}, 32'd0);
        chk32("R1 paging_en", {31'd0, paging_en}, 32'd0);
        chk32("R1 prot_en", {31'd0, prot_en}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wen; wr_sel = VECS[i].sel; wr_data = VECS[i].wd;
            msw_ld = VECS[i].mld; msw_data = VECS[i].md; task_switch = VECS[i].tsw;
            esc_op = VECS[i].esc; wait_op = VECS[i].wt; pf_valid = VECS[i].pf;
            pf_addr = VECS[i].pa; rd_sel = VECS[i].rsel;
            @(posedge clk);
            #1;
            chk32($sformatf("vector %0d read (R2..R11)", i), rd_data, VECS[i].exp);
            chk32($sformatf("vector %0d exc_valid (R5 R6)", i), {31'd0, exc_valid}, {31'd0, VECS[i].ex});
            if (VECS[i].ex)
                chk32($sformatf("vector %0d exc_vector R5", i), {24'd0, exc_vector}, 32'd7);
            chk32($sformatf("vector %0d tlb_flush R9", i), {31'd0, tlb_flush}, {31'd0, VECS[i].fl});
            if (i == 10) begin
                chk32("R2 paging_en", {31'd0, paging_en}, 32'd1);
                chk32("R2 prot_en", {31'd0, prot_en}, 32'd0);
            end
        end
        idle_inputs();

        // R10: reserved write left other registers intact
        rd_sel = 2'd0; #0.1 chk32("R10 control word kept", rd_data, 32'h0000_0008);
        rd_sel = 2'd2; #0.1 chk32("R10 fault address kept", rd_data, 32'h1234_5678);
        rd_sel = 2'd3; #0.1 chk32("R10 root kept", rd_data, 32'hABCD_E000);
        // R3: status word view
        chk32("R3 msw_out", {16'd0, msw_out}, 32'h0000_0008);

        // R1: reset mid-run clears all
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #0.1 chk32("R1 mid-run reset read", rd_data, 32'h0);
        end
        chk32("R1 msw_out after reset", {16'd0, msw_out}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule